// File: doc/BRIEF.md
# MDIO Management Bus Master

This block runs register transfers to and from Ethernet PHY devices over a two-wire management bus. It generates the management clock from the system clock and drives the data line through a separate value and enable, so the tristate buffer lives in the pad ring. It samples the returning line on `mdio_i`. A host hands it one request at a time: a direction flag, a 5-bit PHY address, a 5-bit register address and, for writes, a 16-bit word. The block then sends one complete frame: a preamble, start and opcode bits, both addresses, a turnaround, and the 16 data bits.

On reads the block checks the turnaround bit the PHY is supposed to pull low. If the line stays high, no device answered. The block then keeps clocking with the line released to flush any half-awake PHY. It returns all ones and raises a no-device flag. On a good read the captured word is returned once the trailing idle clocks have gone out.

The request side is a valid/ready port. `req_ready` is high only while no frame is in flight, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. While `req_ready` is low the host must hold its fields and may keep `req_valid` asserted; nothing is queued, and a request offered while busy has no effect. Once accepted, the host may change or drop the fields at once, because the block has latched them. Results need no handshake: `done` pulses once and the result outputs stay put until the next acceptance.

Top module: `mdio_master`

## Requirements
- R1: After reset `mdc` is 0, `mdio_oe` is 0, `req_ready` is 1, `done` is 0, `no_phy` is 0 and `rd_data` is 0.
- R2: Every frame opens with 32 MDC cycles in which the line is driven (`mdio_oe`=1) with value 1.
- R3: MDC cycles 32..35 are driven with start bits 0,1 and then opcode 1,0 for a read (`req_write`=0) or 0,1 for a write (`req_write`=1).
- R4: MDC cycles 36..40 carry the PHY address and cycles 41..45 the register address, each most significant bit first, driven.
- R5: A write drives turnaround 1,0 in cycles 46..47 and then `req_wdata` MSB first in cycles 48..63. It releases the line (`mdio_oe`=0) for cycle 64, the last of 65 MDC cycles.
- R6: A read releases the line from cycle 46 onward. It samples `mdio_i` at the end of the MDC-high half of cycle 46, which must be 0, and of cycles 47..62, building the word MSB first. Two released cycles (63, 64) end the 65-cycle frame, and `rd_data` then holds the word with `no_phy`=0.
- R7: If the sample of cycle 46 is 1, the read runs 32 more released cycles (79 in total) and ends with `rd_data`=0xFFFF and `no_phy`=1.
- R8: `mdio_o` and `mdio_oe` change only in the system cycle where MDC falls or while MDC is low, never during an MDC-high half.
- R9: Each MDC half period lasts HALF_DIV system clocks, ceil(SYS_CLK_HZ / (2*MDC_MAX_HZ)), which is 50 by default. Each bus cycle is a low half followed by a high half, and a frame ends only after a high half.
- R10: A request is accepted only when `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from acceptance until the frame ends. Requests offered while busy start no frame and alter nothing in the frame in flight.
- R11: `done` is a single-cycle pulse in the cycle the frame ends, with `req_ready` already 1. `rd_data` changes only when a read ends. `no_phy` is cleared when the next request is accepted, and a write leaves `rd_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host offers a request |
| req_ready | output | 1 | Block is idle and takes a request this cycle |
| req_write | input | 1 | 1 = write frame, 0 = read frame |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address within the PHY |
| req_wdata | input | 16 | Word to write (ignored on reads) |
| rd_data | output | 16 | Result of the last finished read |
| done | output | 1 | One-cycle pulse at frame end |
| no_phy | output | 1 | Last read saw no PHY answer |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Value to drive on the data line |
| mdio_oe | output | 1 | Drive enable for the data line |
| mdio_i | input | 1 | Sampled data line |

## Verification
The bench models a PHY that either answers with a chosen word or leaves the line pulled high. It records the drive value and enable at every MDC rise and compares the preamble, header, turnaround and data sections against frames computed from the request.

The corner cases it targets are these:
- An absent PHY. A design that skipped the turnaround check would return 0xFFFF after 65 cycles with no flag; one that forgot the flush would give 65 cycles instead of 79.
- Read words with the edge bits set and cleared. A design that sampled on the wrong half or one cycle off would return the word shifted.
- A write with trailing zeros. A design that left the line driven at the end would show up in the enable captured for cycle 64.
- Requests offered while busy, followed by an idle wait. These expose a block that latches fields mid-frame or starts an extra frame.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
  // Frame sections in transmit order; each lasts a known number of MDC cycles.
  typedef enum logic [3:0] {
    SEG_IDLE,
    SEG_PRE,
    SEG_HDR,
    SEG_WTA,
    SEG_WDATA,
    SEG_WREL,
    SEG_RTA,
    SEG_RDATA,
    SEG_RTRAIL,
    SEG_FLUSH
  } seg_e;

  localparam int unsigned WTA_CYC    = 2;
  localparam int unsigned WREL_CYC   = 1;
  localparam int unsigned RTA_CYC    = 1;
  localparam int unsigned RTRAIL_CYC = 2;
  localparam logic [1:0]  START_BITS = 2'b01;
  localparam logic [1:0]  OP_READ    = 2'b10;
  localparam logic [1:0]  OP_WRITE   = 2'b01;
endpackage

// File: rtl/mdio_mdc_gen.sv
`timescale 1ns/1ps
module mdio_mdc_gen #(
  parameter int unsigned HALF_DIV = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic hi_end
);
  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] TERM = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          phase_q;
  logic          wrap;

  assign wrap = run && (cnt_q == TERM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (!run) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (wrap) begin
      cnt_q   <= '0;
      phase_q <= ~phase_q;
    end else begin
      cnt_q   <= cnt_q + CW'(1);
    end
  end

  assign mdc    = phase_q;
  assign hi_end = wrap && phase_q;

  // R9
  mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !mdc);

  // R9
  end_after_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> $past(mdc));
endmodule

// File: rtl/mdio_frame_seq.sv
`timescale 1ns/1ps
module mdio_frame_seq
  import mdio_pkg::*;
#(
  parameter int unsigned PHY_AW    = 5,
  parameter int unsigned REG_AW    = 5,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned PRE_CYC   = 32,
  parameter int unsigned FLUSH_CYC = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              req_write,
  input  logic [PHY_AW-1:0] req_phy,
  input  logic [REG_AW-1:0] req_reg,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              hi_end,
  input  logic              mdio_i,
  output logic              busy,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              cap_en,
  output logic              fin_ok,
  output logic              fin_nophy,
  output logic              done
);
  localparam int unsigned HDR_W  = 4 + PHY_AW + REG_AW;
  localparam int unsigned M1     = (PRE_CYC > FLUSH_CYC) ? PRE_CYC : FLUSH_CYC;
  localparam int unsigned M2     = (DATA_W > HDR_W) ? DATA_W : HDR_W;
  localparam int unsigned MAXLEN = (M1 > M2) ? M1 : M2;
  localparam int unsigned CW     = $clog2(MAXLEN + 1);

  function automatic int unsigned seg_len(seg_e s);
    case (s)
      SEG_PRE:              return PRE_CYC;
      SEG_HDR:              return HDR_W;
      SEG_WTA:              return WTA_CYC;
      SEG_WDATA, SEG_RDATA: return DATA_W;
      SEG_WREL:             return WREL_CYC;
      SEG_RTA:              return RTA_CYC;
      SEG_RTRAIL:           return RTRAIL_CYC;
      SEG_FLUSH:            return FLUSH_CYC;
      default:              return 1;
    endcase
  endfunction

  seg_e              seg_q, seg_nx;
  logic [CW-1:0]     cnt_q;
  logic              busy_q, wr_q, done_q;
  logic [HDR_W-1:0]  hdr_q;
  logic [DATA_W-1:0] wd_q;
  logic              step, last, adv;

  assign step = busy_q && hi_end;
  assign last = (cnt_q == CW'(seg_len(seg_q) - 1));
  assign adv  = step && last;

  always_comb begin
    case (seg_q)
      SEG_PRE:    seg_nx = SEG_HDR;
      SEG_HDR:    seg_nx = wr_q ? SEG_WTA : SEG_RTA;
      SEG_WTA:    seg_nx = SEG_WDATA;
      SEG_WDATA:  seg_nx = SEG_WREL;
      SEG_RTA:    seg_nx = mdio_i ? SEG_FLUSH : SEG_RDATA;
      SEG_RDATA:  seg_nx = SEG_RTRAIL;
      default:    seg_nx = SEG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q  <= SEG_IDLE;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      wr_q   <= 1'b0;
      hdr_q  <= '0;
      wd_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= adv && (seg_nx == SEG_IDLE);
      if (accept) begin
        busy_q <= 1'b1;
        seg_q  <= SEG_PRE;
        cnt_q  <= '0;
        wr_q   <= req_write;
        hdr_q  <= {START_BITS, (req_write ? OP_WRITE : OP_READ), req_phy, req_reg};
        wd_q   <= req_wdata;
      end else if (step) begin
        if (last) begin
          seg_q <= seg_nx;
          cnt_q <= '0;
          if (seg_nx == SEG_IDLE) busy_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
        if (seg_q == SEG_HDR)   hdr_q <= {hdr_q[HDR_W-2:0], 1'b0};
        if (seg_q == SEG_WDATA) wd_q  <= {wd_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  // Line drive is a pure function of state registers, so it moves only at
  // acceptance or at the end of a high half (when MDC falls).
  always_comb begin
    mdio_oe = 1'b0;
    mdio_o  = 1'b1;
    case (seg_q)
      SEG_PRE:   begin mdio_oe = 1'b1; mdio_o = 1'b1; end
      SEG_HDR:   begin mdio_oe = 1'b1; mdio_o = hdr_q[HDR_W-1]; end
      SEG_WTA:   begin mdio_oe = 1'b1; mdio_o = (cnt_q == '0); end
      SEG_WDATA: begin mdio_oe = 1'b1; mdio_o = wd_q[DATA_W-1]; end
      default:   ;
    endcase
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign cap_en    = step && (seg_q == SEG_RDATA);
  assign fin_ok    = adv && (seg_q == SEG_RTRAIL);
  assign fin_nophy = adv && (seg_q == SEG_FLUSH);

  // R1
  idle_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (seg_q == SEG_IDLE) && !mdio_oe);

  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/mdio_rd_capture.sv
`timescale 1ns/1ps
module mdio_rd_capture #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              cap_en,
  input  logic              bit_in,
  input  logic              fin_ok,
  input  logic              fin_nophy,
  output logic [DATA_W-1:0] rd_data,
  output logic              no_phy
);
  logic [DATA_W-1:0] sr_q, rd_q;
  logic              np_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
      rd_q <= '0;
      np_q <= 1'b0;
    end else begin
      if (cap_en) sr_q <= {sr_q[DATA_W-2:0], bit_in};
      if (clear) np_q <= 1'b0;
      if (fin_ok) begin
        rd_q <= sr_q;
        np_q <= 1'b0;
      end else if (fin_nophy) begin
        rd_q <= '1;
        np_q <= 1'b1;
      end
    end
  end

  assign rd_data = rd_q;
  assign no_phy  = np_q;

  // R7
  nophy_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    np_q |-> (rd_q == '1));
endmodule

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
module mdio_master #(
  parameter int unsigned SYS_CLK_HZ = 250_000_000,
  parameter int unsigned MDC_MAX_HZ = 2_500_000,
  parameter int unsigned PHY_AW     = 5,
  parameter int unsigned REG_AW     = 5,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned PRE_CYC    = 32,
  parameter int unsigned FLUSH_CYC  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [PHY_AW-1:0] req_phy,
  input  logic [REG_AW-1:0] req_reg,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic              no_phy,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam int unsigned HALF_DIV_RAW = (SYS_CLK_HZ + 2*MDC_MAX_HZ - 1) / (2*MDC_MAX_HZ);
  localparam int unsigned HALF_DIV     = (HALF_DIV_RAW < 1) ? 1 : HALF_DIV_RAW;

  logic busy, accept, hi_end, cap_en, fin_ok, fin_nophy;

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  mdio_mdc_gen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (busy),
    .mdc    (mdc),
    .hi_end (hi_end)
  );

  mdio_frame_seq #(
    .PHY_AW(PHY_AW), .REG_AW(REG_AW), .DATA_W(DATA_W),
    .PRE_CYC(PRE_CYC), .FLUSH_CYC(FLUSH_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .req_write (req_write),
    .req_phy   (req_phy),
    .req_reg   (req_reg),
    .req_wdata (req_wdata),
    .hi_end    (hi_end),
    .mdio_i    (mdio_i),
    .busy      (busy),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .cap_en    (cap_en),
    .fin_ok    (fin_ok),
    .fin_nophy (fin_nophy),
    .done      (done)
  );

  mdio_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (accept),
    .cap_en    (cap_en),
    .bit_in    (mdio_i),
    .fin_ok    (fin_ok),
    .fin_nophy (fin_nophy),
    .rd_data   (rd_data),
    .no_phy    (no_phy)
  );

  // R8
  mdio_hold_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  // R10
  accept_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));

  // R11
  done_when_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);
endmodule

// File: tb/tb_mdio_master.sv
`timescale 1ns/1ps
module tb_mdio_master;
  localparam int HP = 50;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [4:0]  req_phy = '0, req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, done, no_phy, mdc, mdio_o, mdio_oe, mdio_i;
  logic [15:0] rd_data;

  always #2 clk = ~clk;

  mdio_master dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_phy(req_phy), .req_reg(req_reg),
    .req_wdata(req_wdata), .rd_data(rd_data), .done(done), .no_phy(no_phy),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int n_run = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- PHY model and line recorder ----------------
  logic         phy_present = 1'b0;
  logic [15:0]  phy_data = '0;
  int           rise_n = 0;
  int           k_cur;
  logic [127:0] cap_v = '0, cap_e = '0;

  always @(posedge mdc) begin
    if (rise_n < 128) begin
      cap_v[rise_n[6:0]] = mdio_o;
      cap_e[rise_n[6:0]] = mdio_oe;
    end
    rise_n++;
  end

  // Cycle k is sampled at the end of its high half, while rise_n == k+1.
  always_comb begin
    k_cur  = rise_n - 1;
    mdio_i = 1'b1;
    if (phy_present && k_cur == 46) mdio_i = 1'b0;
    else if (phy_present && k_cur >= 47 && k_cur <= 62) mdio_i = phy_data[4'(62 - k_cur)];
  end

  // ---------------- half-period monitor (R9) ----------------
  int   run_len = 0, hp_bad = 0, hp_seen = 0;
  logic mdc_prev = 1'b0;
  bit   low_valid = 1'b0;

  always @(negedge clk) begin
    if (mdc !== mdc_prev) begin
      if (mdc_prev == 1'b1) begin
        hp_seen++;
        if (run_len != HP) hp_bad++;
        low_valid = !req_ready;
      end else if (low_valid) begin
        hp_seen++;
        if (run_len != HP) hp_bad++;
      end
      run_len  = 1;
      mdc_prev = mdc;
    end else begin
      run_len++;
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct packed {
    logic [127:0] v;
    logic [127:0] e;
    logic [7:0]   n;
    logic [15:0]  rd;
    logic         np;
    logic [1:0]   kind;   // 0 write, 1 read, 2 absent PHY
  } exp_t;

  exp_t        sbq[$];
  exp_t        cur;
  logic [15:0] model_rd = '0;

  function automatic logic [127:0] rmask(input int lo, input int hi);
    logic [127:0] m;
    m = '0;
    for (int i = lo; i <= hi; i++) m[i] = 1'b1;
    return m;
  endfunction

  function automatic exp_t build(input logic wr, input logic [4:0] phy,
                                 input logic [4:0] rg, input logic [15:0] wd,
                                 input logic present, input logic [15:0] pdata);
    exp_t x;
    int   i;
    logic [3:0] so;
    x  = '0;
    i  = 0;
    so = wr ? 4'b0101 : 4'b0110;
    for (int p = 0; p < 32; p++) begin x.v[i] = 1'b1; x.e[i] = 1'b1; i++; end
    for (int p = 3; p >= 0; p--) begin x.v[i] = so[p]; x.e[i] = 1'b1; i++; end
    for (int p = 4; p >= 0; p--) begin x.v[i] = phy[p]; x.e[i] = 1'b1; i++; end
    for (int p = 4; p >= 0; p--) begin x.v[i] = rg[p]; x.e[i] = 1'b1; i++; end
    if (wr) begin
      x.v[i] = 1'b1; x.e[i] = 1'b1; i++;
      x.v[i] = 1'b0; x.e[i] = 1'b1; i++;
      for (int p = 15; p >= 0; p--) begin x.v[i] = wd[p]; x.e[i] = 1'b1; i++; end
      x.n = 8'd65; x.rd = model_rd; x.np = 1'b0; x.kind = 2'd0;
    end else if (present) begin
      x.n = 8'd65; x.rd = pdata; x.np = 1'b0; x.kind = 2'd1;
    end else begin
      x.n = 8'd79; x.rd = 16'hFFFF; x.np = 1'b1; x.kind = 2'd2;
    end
    return x;
  endfunction

  task automatic cmp_range(input int lo, input int hi, input string req, input string what);
    logic [127:0] m;
    m = rmask(lo, hi);
    chk(((cap_v & cap_e & m) === (cur.v & cur.e & m)) && ((cap_e & m) === (cur.e & m)),
        req, {what, " value"}, cap_v & cap_e & m, cur.v & cur.e & m);
    chk((cap_e & m) === (cur.e & m), req, {what, " enable"}, cap_e & m, cur.e & m);
  endtask

  always @(negedge clk) begin
    if (done) begin
      if (sbq.size() == 0) begin
        chk(1'b0, "R11", "done with no frame outstanding", 128'(done), 128'(0));
      end else begin
        cur = sbq.pop_front();
        cmp_range(0, 31, "R2", "preamble");
        cmp_range(32, 35, "R3", "start/opcode");
        cmp_range(36, 45, "R4", "addresses");
        case (cur.kind)
          2'd0:    cmp_range(46, 64, "R5", "write tail");
          2'd1:    cmp_range(46, 64, "R6", "read tail released");
          default: cmp_range(46, 78, "R7", "flush released");
        endcase
        chk(rise_n == int'(cur.n), cur.kind == 2'd0 ? "R5" : (cur.kind == 2'd1 ? "R6" : "R7"),
            "MDC cycle count", 128'(rise_n), 128'(cur.n));
        chk(rd_data === cur.rd, cur.kind == 2'd0 ? "R11" : (cur.kind == 2'd1 ? "R6" : "R7"),
            "rd_data at done", 128'(rd_data), 128'(cur.rd));
        chk(no_phy === cur.np, cur.kind == 2'd2 ? "R7" : "R11", "no_phy at done",
            128'(no_phy), 128'(cur.np));
        chk(req_ready === 1'b1, "R11", "ready at done", 128'(req_ready), 128'(1));
      end
    end
  end

  // ---------------- driver ----------------
  task automatic do_req(input logic wr, input logic [4:0] phy, input logic [4:0] rg,
                        input logic [15:0] wd, input logic present,
                        input logic [15:0] pdata, input bit poke);
    exp_t x;
    bit   busy_ok;
    x = build(wr, phy, rg, wd, present, pdata);
    sbq.push_back(x);
    model_rd    = x.rd;
    phy_present = present;
    phy_data    = pdata;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_phy = phy; req_reg = rg; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    rise_n = 0; cap_v = '0; cap_e = '0;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready === 1'b0, "R10", "ready low after acceptance", 128'(req_ready), 128'(0));
    if (poke) begin
      busy_ok = 1'b1;
      repeat (300) @(negedge clk);
      for (int j = 0; j < 20; j++) begin
        req_valid = 1'b1; req_write = ~wr; req_phy = ~phy; req_reg = ~rg; req_wdata = ~wd;
        @(negedge clk);
        if (req_ready !== 1'b0) busy_ok = 1'b0;
      end
      req_valid = 1'b0;
      chk(busy_ok, "R10", "ready stayed low while busy", 128'(busy_ok), 128'(1));
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(done === 1'b0, "R11", "done width one cycle", 128'(done), 128'(0));
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    repeat (5) @(negedge clk);
    chk({mdc, mdio_oe, req_ready, done, no_phy} === 5'b00100, "R1", "pins in reset",
        128'({mdc, mdio_oe, req_ready, done, no_phy}), 128'(5'b00100));
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk({mdc, mdio_oe, req_ready, done, no_phy} === 5'b00100, "R1", "pins after reset",
        128'({mdc, mdio_oe, req_ready, done, no_phy}), 128'(5'b00100));
    chk(rd_data === 16'h0000, "R1", "rd_data after reset", 128'(rd_data), 128'(0));

    do_req(1'b1, 5'h01, 5'h00, 16'hA5C3, 1'b1, 16'h0000, 1'b0);   // R5 write
    do_req(1'b0, 5'h1F, 5'h15, 16'h0000, 1'b1, 16'h8001, 1'b0);   // R6 read, edge bits
    repeat (200) @(negedge clk);
    chk(rd_data === 16'h8001, "R11", "rd_data held while idle", 128'(rd_data), 128'(16'h8001));
    do_req(1'b0, 5'h10, 5'h02, 16'h0000, 1'b0, 16'h0000, 1'b0);   // R7 absent PHY
    do_req(1'b1, 5'h0A, 5'h1F, 16'h0000, 1'b1, 16'h0000, 1'b1);   // R10 pokes, R11 flag clear
    repeat (400) @(negedge clk);
    chk(rise_n == 65 && mdio_oe === 1'b0 && req_ready === 1'b1, "R10",
        "no extra frame after busy pokes", 128'(rise_n), 128'(65));
    do_req(1'b0, 5'h00, 5'h01, 16'h0000, 1'b1, 16'h7FFE, 1'b0);   // R6 read, inverted edges
    do_req(1'b1, 5'h15, 5'h0A, 16'hFFFF, 1'b1, 16'h0000, 1'b0);   // R5 all-ones write

    chk(hp_bad == 0 && hp_seen > 0, "R9", "MDC half periods of HALF_DIV clocks",
        128'(hp_bad), 128'(0));
    chk(sbq.size() == 0, "R11", "every frame produced done", 128'(sbq.size()), 128'(0));
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule